// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the byte address of the instruction being executed and works out, every clock, where the next instruction is. A decoder upstream reduces the current instruction to a transfer kind. It also passes the raw 16-bit offset field, the raw 26-bit target field, the two register values a conditional branch compares, and the register value an indirect jump uses. The unit answers with the current address, the return address for a linking jump, and a flag that marks a redirect, so a pipeline knows when to discard the instructions it has already fetched.

Conditional branches are relative. The signed offset counts instructions, not bytes, so it is scaled by four and added to the address of the following instruction. Direct jumps stay inside the current 256 MB region: the top four bits of the current address are kept and the target field plus two zero bits fill the rest. An indirect jump can reach any address. All address sums wrap modulo 2^32 and no overflow is reported.

Top module: `nextPcUnit`

## Requirements
- R1: When `rst` is high at a rising clock edge, `pcOut` becomes 0x0000_0000 after that edge, whatever `advance` and the other inputs are.
- R2: When `advance` is low and `rst` is low, `pcOut` keeps its value across the edge for every transfer kind.
- R3: Kind code 0 (sequential) with `advance` high moves `pcOut` to `pcOut + 4`.
- R4: Kind code 1 (branch if equal) moves `pcOut` to `pcOut + 4 + (sign-extended offset × 4)` when `opA == opB`, and to `pcOut + 4` otherwise.
- R5: Kind code 2 (branch if not equal) takes the relative target when `opA != opB`, and moves to `pcOut + 4` otherwise.
- R6: Address sums wrap modulo 2^32. An offset of 0x8000 reaches back 2^15 instructions, and a sum that crosses 0xFFFF_FFFC or 0 wraps around.
- R7: Kind code 3 (direct jump) loads `{pcOut[31:28], jumpField, 2'b00}`.
- R8: Kind code 4 (linking jump) loads the same target as R7, and `linkOut` shows `pcOut + 4` during that cycle.
- R9: Kind code 5 (indirect jump) loads all 32 bits of `regTarget`.
- R10: `takenOut` is high in a cycle exactly when the kind is 3, 4 or 5, or when it is a branch whose condition holds. This does not depend on `advance`.
- R11: Kind codes 6 and 7 behave as sequential, with `takenOut` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Lets the address register load its next value |
| kindIn | input | 3 | Transfer kind code |
| offsetField | input | 16 | Signed branch offset, counted in instructions |
| jumpField | input | 26 | Word target of a direct jump |
| opA | input | 32 | First compared register value |
| opB | input | 32 | Second compared register value |
| regTarget | input | 32 | Full address for an indirect jump |
| pcOut | output | 32 | Current instruction address |
| linkOut | output | 32 | Return address, current address plus 4 |
| takenOut | output | 1 | Redirect in this cycle |

## Verification
The hardest cases to reach are the wrap-around corners: a branch with the most negative offset taken from near address 0, and a forward branch that lands past 0xFFFF_FFFC. The pc register can only be preloaded through the ports, so the stimulus first uses an indirect jump to put the address into a high region. It then runs forward across a region boundary, and chains branches whose results wrap in both directions. Hold cycles with a redirecting kind present check that the flag reports the transfer while the address stays put.

// File: rtl/npcPkg.sv
package npcPkg;

  typedef enum logic [2:0] {
    XF_SEQ  = 3'd0,
    XF_BEQ  = 3'd1,
    XF_BNE  = 3'd2,
    XF_JMP  = 3'd3,
    XF_JAL  = 3'd4,
    XF_JREG = 3'd5
  } xferKind_e;

  // strobes from control to datapath; at most one select is high
  typedef struct packed {
    logic selRel;   // relative branch target
    logic selAbs;   // region-local direct target
    logic selReg;   // full register target
    logic redirect; // any of the above
  } npcStrobe_t;

endpackage

// File: rtl/npcControl.sv
module npcControl
  import npcPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        kindIn,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output npcStrobe_t        strobe
);

  logic operandsMatch;
  xferKind_e kind;

  assign operandsMatch = (opA == opB);
  assign kind          = xferKind_e'(kindIn);

  always_comb begin
    strobe = '0;
    unique case (kind)
      XF_BEQ:  strobe.selRel = operandsMatch;
      XF_BNE:  strobe.selRel = !operandsMatch;
      XF_JMP,
      XF_JAL:  strobe.selAbs = 1'b1;
      XF_JREG: strobe.selReg = 1'b1;
      default: strobe = '0; // sequential and unused codes
    endcase
    strobe.redirect = strobe.selRel | strobe.selAbs | strobe.selReg;
  end

endmodule

// File: rtl/npcDatapath.sv
module npcDatapath
  import npcPkg::*;
#(
  parameter int              PC_W     = 32,
  parameter int              OFF_W    = 16,
  parameter int              TGT_W    = 26,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  npcStrobe_t       strobe,
  input  logic [OFF_W-1:0] offsetField,
  input  logic [TGT_W-1:0] jumpField,
  input  logic [PC_W-1:0]  regTarget,
  output logic [PC_W-1:0]  pcQ,
  output logic [PC_W-1:0]  seqPc
);

  localparam int ALIGN_W = 2;
  localparam int REGION_W = PC_W - TGT_W - ALIGN_W;
  localparam int EXT_W = PC_W - OFF_W - ALIGN_W;
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [PC_W-1:0] byteOffset;
  logic [PC_W-1:0] relPc;
  logic [PC_W-1:0] absPc;
  logic [PC_W-1:0] nextPc;

  assign seqPc      = pcQ + STEP;
  assign byteOffset = {{EXT_W{offsetField[OFF_W-1]}}, offsetField, {ALIGN_W{1'b0}}};
  assign relPc      = seqPc + byteOffset;
  assign absPc      = {pcQ[PC_W-1 -: REGION_W], jumpField, {ALIGN_W{1'b0}}};

  always_comb begin
    nextPc = seqPc;
    if (strobe.selRel)      nextPc = relPc;
    else if (strobe.selAbs) nextPc = absPc;
    else if (strobe.selReg) nextPc = regTarget;
  end

  always_ff @(posedge clk) begin
    if (rst)          pcQ <= RESET_PC;
    else if (advance) pcQ <= nextPc;
  end

endmodule

// File: rtl/nextPcUnit.sv
module nextPcUnit
  import npcPkg::*;
#(
  parameter int              PC_W     = 32,
  parameter int              OFF_W    = 16,
  parameter int              TGT_W    = 26,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic [2:0]       kindIn,
  input  logic [OFF_W-1:0] offsetField,
  input  logic [TGT_W-1:0] jumpField,
  input  logic [PC_W-1:0]  opA,
  input  logic [PC_W-1:0]  opB,
  input  logic [PC_W-1:0]  regTarget,
  output logic [PC_W-1:0]  pcOut,
  output logic [PC_W-1:0]  linkOut,
  output logic             takenOut
);

  npcStrobe_t strobe;

  npcControl #(.DATA_W(PC_W)) u_ctrl (
    .kindIn (kindIn),
    .opA    (opA),
    .opB    (opB),
    .strobe (strobe)
  );

  npcDatapath #(
    .PC_W(PC_W), .OFF_W(OFF_W), .TGT_W(TGT_W), .RESET_PC(RESET_PC)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .advance     (advance),
    .strobe      (strobe),
    .offsetField (offsetField),
    .jumpField   (jumpField),
    .regTarget   (regTarget),
    .pcQ         (pcOut),
    .seqPc       (linkOut)
  );

  assign takenOut = strobe.redirect;

endmodule

// File: rtl/npcChecker.sv
module npcChecker #(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input logic            clk,
  input logic            rst,
  input logic            advance,
  input logic [2:0]      kindIn,
  input logic [PC_W-1:0] opA,
  input logic [PC_W-1:0] opB,
  input logic [PC_W-1:0] regTarget,
  input logic [PC_W-1:0] pcOut,
  input logic            takenOut
);

  assert_reset_start_R1: assert property (@(posedge clk)
    rst |=> pcOut == RESET_PC);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(pcOut));

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
    (advance && kindIn == 3'd0) |=> pcOut == $past(pcOut) + 32'd4);

  assert_beq_fallthru_R4: assert property (@(posedge clk) disable iff (rst)
    (advance && kindIn == 3'd1 && opA != opB) |=> pcOut == $past(pcOut) + 32'd4);

  assert_bne_fallthru_R5: assert property (@(posedge clk) disable iff (rst)
    (advance && kindIn == 3'd2 && opA == opB) |=> pcOut == $past(pcOut) + 32'd4);

  assert_jump_region_R7: assert property (@(posedge clk) disable iff (rst)
    (advance && kindIn == 3'd3) |=>
      (pcOut[PC_W-1 -: 4] == $past(pcOut[PC_W-1 -: 4])) && (pcOut[1:0] == 2'b00));

  assert_indirect_R9: assert property (@(posedge clk) disable iff (rst)
    (advance && kindIn == 3'd5) |=> pcOut == $past(regTarget));

  assert_jump_flag_R10: assert property (@(posedge clk) disable iff (rst)
    (kindIn == 3'd3 || kindIn == 3'd4 || kindIn == 3'd5) |-> takenOut);

  assert_seq_flag_R11: assert property (@(posedge clk) disable iff (rst)
    (kindIn == 3'd0 || kindIn == 3'd6 || kindIn == 3'd7) |-> !takenOut);

endmodule

bind nextPcUnit npcChecker #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .advance   (advance),
  .kindIn    (kindIn),
  .opA       (opA),
  .opB       (opB),
  .regTarget (regTarget),
  .pcOut     (pcOut),
  .takenOut  (takenOut)
);

// File: tb/sim_nextPcUnit.sv
module sim_nextPcUnit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        advance = 1'b0;
  logic [2:0]  kindIn = 3'd0;
  logic [15:0] offsetField = '0;
  logic [25:0] jumpField = '0;
  logic [31:0] opA = '0, opB = '0, regTarget = '0;
  logic [31:0] pcOut, linkOut;
  logic        takenOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  nextPcUnit u0 (
    .clk(clk), .rst(rst), .advance(advance), .kindIn(kindIn),
    .offsetField(offsetField), .jumpField(jumpField),
    .opA(opA), .opB(opB), .regTarget(regTarget),
    .pcOut(pcOut), .linkOut(linkOut), .takenOut(takenOut)
  );

  typedef struct {
    logic [31:0] nextPc;
    logic [31:0] link;
    logic        taken;
    bit          chkComb;
    string       tag;
  } expItem_t;

  expItem_t    sbQueue[$];
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;
  logic [31:0] modelPc = '0;

  task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic doReset(string tag);
    expItem_t it;
    @(negedge clk);
    rst = 1'b1;
    advance = 1'b1; // reset must win over advance
    kindIn = 3'd5;
    regTarget = 32'h1234_5678;
    it.nextPc = 32'h0; it.link = '0; it.taken = 1'b0; it.chkComb = 0; it.tag = tag;
    modelPc = 32'h0;
    sbQueue.push_back(it);
  endtask

  task automatic drive(string tag, logic [2:0] k, logic [15:0] off, logic [25:0] tgt,
                       logic [31:0] a, logic [31:0] b, logic [31:0] r, logic adv);
    expItem_t it;
    logic        tk;
    logic [31:0] nxt;
    logic [31:0] seqAddr;
    @(negedge clk);
    rst = 1'b0; advance = adv; kindIn = k; offsetField = off;
    jumpField = tgt; opA = a; opB = b; regTarget = r;
    seqAddr = modelPc + 32'd4;
    tk = 1'b0; nxt = seqAddr;
    case (k)
      3'd1: if (a == b) begin tk = 1'b1; nxt = seqAddr + {{14{off[15]}}, off, 2'b00}; end
      3'd2: if (a != b) begin tk = 1'b1; nxt = seqAddr + {{14{off[15]}}, off, 2'b00}; end
      3'd3, 3'd4: begin tk = 1'b1; nxt = {modelPc[31:28], tgt, 2'b00}; end
      3'd5: begin tk = 1'b1; nxt = r; end
      default: ;
    endcase
    it.link = seqAddr; it.taken = tk; it.chkComb = 1; it.tag = tag;
    if (adv) modelPc = nxt;
    it.nextPc = modelPc;
    sbQueue.push_back(it);
  endtask

  // monitor: compares the combinational outputs mid-cycle, the register after the edge
  initial begin
    forever begin
      expItem_t it;
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (sbQueue.size() > 0) begin
        it = sbQueue.pop_front();
        if (it.chkComb) begin
          check32(it.tag, "takenOut", {31'b0, takenOut}, {31'b0, it.taken});
          check32(it.tag, "linkOut", linkOut, it.link);
        end
        @(posedge clk);
        #1;
        check32(it.tag, "pcOut", pcOut, it.nextPc);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    doReset("R1");
    // R3: plain stepping
    drive("R3", 3'd0, 16'h0, 26'h0, 32'h1, 32'h1, 32'h0, 1'b1);
    drive("R3", 3'd0, 16'h0, 26'h0, 32'h1, 32'h1, 32'h0, 1'b1);
    drive("R3", 3'd0, 16'h0, 26'h0, 32'h0, 32'h0, 32'h0, 1'b1);
    // R2: hold, and R10 flag still reported on hold
    drive("R2", 3'd0, 16'h0, 26'h0, 32'h0, 32'h0, 32'h0, 1'b0);
    drive("R2_R10", 3'd3, 16'h0, 26'h3F, 32'h0, 32'h0, 32'h0, 1'b0);
    drive("R2_R10", 3'd1, 16'h7, 26'h0, 32'h5, 32'h5, 32'h0, 1'b0);
    // R4 / R5 branches
    drive("R4", 3'd1, 16'h0005, 26'h0, 32'hAA, 32'hAA, 32'h0, 1'b1);
    drive("R4", 3'd1, 16'h0005, 26'h0, 32'hAA, 32'hAB, 32'h0, 1'b1);
    drive("R5", 3'd2, 16'hFFFE, 26'h0, 32'h1, 32'h2, 32'h0, 1'b1);
    drive("R5", 3'd2, 16'hFFFE, 26'h0, 32'h9, 32'h9, 32'h0, 1'b1);
    // R9 / R7 / R8 jumps
    drive("R9", 3'd5, 16'h0, 26'h0, 32'h0, 32'h0, 32'hA000_0000, 1'b1);
    drive("R7", 3'd3, 16'h0, 26'h123456, 32'h0, 32'h0, 32'h0, 1'b1);
    drive("R8", 3'd4, 16'h0, 26'h3FFFFFF, 32'h0, 32'h0, 32'h0, 1'b1);
    drive("R3", 3'd0, 16'h0, 26'h0, 32'h0, 32'h0, 32'h0, 1'b1);
    drive("R7", 3'd3, 16'h0, 26'h0000001, 32'h0, 32'h0, 32'h0, 1'b1);
    // R6 wrap-around corners
    drive("R9", 3'd5, 16'h0, 26'h0, 32'h0, 32'h0, 32'hFFFF_FFFC, 1'b1);
    drive("R6", 3'd0, 16'h0, 26'h0, 32'h0, 32'h0, 32'h0, 1'b1);
    drive("R6", 3'd1, 16'h8000, 26'h0, 32'h3, 32'h3, 32'h0, 1'b1);
    drive("R6", 3'd2, 16'h7FFF, 26'h0, 32'h3, 32'h4, 32'h0, 1'b1);
    // R11 unused codes
    drive("R11", 3'd6, 16'h0010, 26'h55, 32'h7, 32'h7, 32'hDEAD_BEEC, 1'b1);
    drive("R11", 3'd7, 16'h0010, 26'h55, 32'h7, 32'h8, 32'hDEAD_BEEC, 1'b1);
    // R1 reset mid-run with advance high and a redirect present
    doReset("R1");
    drive("R3", 3'd0, 16'h0, 26'h0, 32'h0, 32'h0, 32'h0, 1'b1);
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule